// File: doc/BRIEF.md
# Packet Header Malformation Checker

This block watches a stream of 32-bit double words that carries one transaction-layer packet at a time. A start marker and an end marker frame each packet. From the first header word it pulls out the format code, the type code, the traffic class, the three ordering and snoop hints, the digest-present bit and the payload length. From the format code it works out two things: whether the header is three or four words long, and whether a payload follows it.

While the packet streams in, the checker counts the words that follow the header. When the end word arrives, it compares that count with what the header promised: the payload length, where a length field of zero means 1024 words, plus one digest word if the digest bit is set. For memory requests with a four-word header, it also checks the upper address word. One cycle after the end word it raises a result strobe. The strobe carries a malformed flag, a reason code and the decoded fields. The block does not compute any CRC and makes no routing or ordering decisions.

Top module: `pkt_hdr_checker`

## Requirements
- R1: The first word of a packet is decoded as follows. Format is bits 31:29 and type is bits 28:24. Traffic class is bits 22:20. The ID-based-ordering hint is bit 18 and the digest-present bit is bit 15. Relaxed ordering is bit 13 and no-snoop is bit 12. Length is bits 9:0. Each of these is presented unchanged on the result outputs.
- R2: `res_length` gives the payload size in words. A length field of 0 reads as 1024; any other value N reads as N.
- R3: A format with bit 0 set has a 4-word header, otherwise the header is 3 words. A packet that ends before its header is complete gets reason 2.
- R4: A format code with bit 2 set (1xx) is unsupported and gets reason 1.
- R5: A request with format 001 or 011 and type 00000 or 00001 gets reason 3 when header word 2 (the upper address word) is zero. Other types are not subject to this rule.
- R6: For a format with payload (01x), reason 4 is given when fewer words follow the header than the decoded length.
- R7: When the digest bit is set, the word after the payload is the digest, and the payload is empty for formats without payload. If exactly the payload arrives and no digest word follows, the reason is 5.
- R8: Reason 6 is given when more words follow the header than the payload plus digest allow. For formats without payload the length field is ignored, so any word beyond the header and the flagged digest counts as excess.
- R9: `res_valid` is high for exactly the one cycle after the clock edge that accepts the end word. `res_malformed` equals (reason != 0), and a well-formed packet reports reason 0.
- R10: A valid word that arrives outside a packet without a start marker is ignored and yields no result.
- R11: A start marker in the middle of a packet abandons that packet without a result and begins a new one.
- R12: When several faults apply, the lowest reason code wins, in the order 1, 2, 3, 4, 5, 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A stream word is present |
| in_sop | input | 1 | The word is the first of a packet |
| in_eop | input | 1 | The word is the last of a packet |
| in_data | input | 32 | Stream word |
| res_valid | output | 1 | Result strobe, one cycle |
| res_malformed | output | 1 | Packet is malformed |
| res_reason | output | 3 | Reason code (0 means well formed) |
| res_fmt | output | 3 | Decoded format code |
| res_kind | output | 5 | Decoded type code |
| res_tc | output | 3 | Decoded traffic class |
| res_relaxed | output | 1 | Relaxed-ordering hint |
| res_nosnoop | output | 1 | No-snoop hint |
| res_idbased | output | 1 | ID-based-ordering hint |
| res_digest | output | 1 | Digest-present bit |
| res_length | output | 11 | Decoded payload length in words |

## Verification
The assertions check, on every cycle, a set of consistency rules on the result:
- a strobe only ever follows an accepted end word;
- an unsupported format always reports reason 1;
- the address reason only appears with a memory type and a four-word format;
- the missing-digest reason only appears with the digest bit set;
- a short-header verdict never appears with an unsupported format.

The following can only be shown by the bench's scenarios, which compare each result against a model that counts words independently:
- the exact word counting, including the 1024-word case that a zero length field stands for;
- the ignored length on formats without payload;
- the abandonment of a packet when a new start marker arrives;
- the silence for stray words outside a packet;
- the priority between faults that occur together.

// File: rtl/phc_pkg.sv
package phc_pkg;
   localparam int DW_BITS  = 32;
   localparam int LEN_BITS = 10;

   typedef logic [2:0] reason_t;
   localparam reason_t RSN_OK        = 3'd0;
   localparam reason_t RSN_BAD_FMT   = 3'd1;
   localparam reason_t RSN_HDR_SHORT = 3'd2;
   localparam reason_t RSN_ADDR_LOW  = 3'd3;
   localparam reason_t RSN_PAY_SHORT = 3'd4;
   localparam reason_t RSN_NO_DIGEST = 3'd5;
   localparam reason_t RSN_EXCESS    = 3'd6;

   typedef struct packed {
      logic [2:0]          fmt;
      logic [4:0]          kind;
      logic [2:0]          tc;
      logic                relaxed;
      logic                nosnoop;
      logic                idbased;
      logic                digest;
      logic [LEN_BITS-1:0] len_raw;
   } hdr_t;

   // zero encodes the maximum payload
   function automatic logic [LEN_BITS:0] len_words(input logic [LEN_BITS-1:0] raw);
      len_words = (raw == '0) ? {1'b1, {LEN_BITS{1'b0}}} : {1'b0, raw};
   endfunction
endpackage

// File: rtl/phc_hdr_decode.sv
module phc_hdr_decode
   import phc_pkg::*;
(
   input  logic [DW_BITS-1:0] dw0,
   output hdr_t               hdr
);
   always_comb begin
      hdr.fmt     = dw0[31:29];
      hdr.kind    = dw0[28:24];
      hdr.tc      = dw0[22:20];
      hdr.idbased = dw0[18];
      hdr.digest  = dw0[15];
      hdr.relaxed = dw0[13];
      hdr.nosnoop = dw0[12];
      hdr.len_raw = dw0[LEN_BITS-1:0];
   end
endmodule

// File: rtl/phc_tracker.sv
module phc_tracker
   import phc_pkg::*;
#(
   parameter int CNT_W = 12
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic               in_sop,
   input  logic               in_eop,
   input  logic [DW_BITS-1:0] in_data,
   input  hdr_t               dec_hdr,
   output hdr_t               cur_hdr,
   output logic [CNT_W-1:0]   cur_idx,
   output logic               hi_zero,
   output logic               take
);
   localparam logic [CNT_W-1:0] ADDR_HI_IDX = CNT_W'(2);

   logic             busy_q;
   logic [CNT_W-1:0] wcnt_q;
   hdr_t             saved_q;
   logic             hi_zero_q;

   always_comb begin
      take    = in_valid && (in_sop || busy_q);
      cur_idx = in_sop ? '0 : wcnt_q;
      cur_hdr = in_sop ? dec_hdr : saved_q;
      hi_zero = hi_zero_q;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         wcnt_q    <= '0;
         saved_q   <= '0;
         hi_zero_q <= 1'b0;
      end else if (take) begin
         busy_q <= !in_eop;
         if (in_sop) saved_q <= dec_hdr;
         if (cur_idx != '1) wcnt_q <= cur_idx + CNT_W'(1);
         else               wcnt_q <= cur_idx;
         if (cur_idx == ADDR_HI_IDX) hi_zero_q <= (in_data == '0);
      end
   end
endmodule

// File: rtl/phc_verdict.sv
module phc_verdict
   import phc_pkg::*;
#(
   parameter int CNT_W        = 12,
   parameter bit ADDR_RULE_EN = 1'b1
) (
   input  hdr_t             hdr,
   input  logic [CNT_W-1:0] cur_idx,
   input  logic             hi_zero,
   output reason_t          reason
);
   localparam int CW = CNT_W + 1;

   logic [CW-1:0] total, hsize, body, exp_len, dig;
   logic          has_pay, addr_hit;

   always_comb begin
      total   = {1'b0, cur_idx} + CW'(1);
      hsize   = hdr.fmt[0] ? CW'(4) : CW'(3);
      body    = total - hsize;
      exp_len = CW'(len_words(hdr.len_raw));
      dig     = CW'(hdr.digest);
      has_pay = hdr.fmt[1];
   end

   generate
      if (ADDR_RULE_EN) begin : g_addr_rule
         assign addr_hit = hdr.fmt[0] && (hdr.kind[4:1] == 4'd0) && hi_zero;
      end else begin : g_no_addr_rule
         assign addr_hit = 1'b0;
      end
   endgenerate

   always_comb begin
      reason = RSN_OK;
      if (hdr.fmt[2])                                 reason = RSN_BAD_FMT;
      else if (total < hsize)                         reason = RSN_HDR_SHORT;
      else if (addr_hit)                              reason = RSN_ADDR_LOW;
      else if (has_pay) begin
         if (body < exp_len)                          reason = RSN_PAY_SHORT;
         else if (hdr.digest && body == exp_len)      reason = RSN_NO_DIGEST;
         else if (body > exp_len + dig)               reason = RSN_EXCESS;
      end else begin
         if (hdr.digest && body == '0)                reason = RSN_NO_DIGEST;
         else if (body > dig)                         reason = RSN_EXCESS;
      end
   end
endmodule

// File: rtl/pkt_hdr_checker.sv
module pkt_hdr_checker
   import phc_pkg::*;
#(
   parameter int CNT_W        = 12,
   parameter bit ADDR_RULE_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic                in_sop,
   input  logic                in_eop,
   input  logic [31:0]         in_data,
   output logic                res_valid,
   output logic                res_malformed,
   output logic [2:0]          res_reason,
   output logic [2:0]          res_fmt,
   output logic [4:0]          res_kind,
   output logic [2:0]          res_tc,
   output logic                res_relaxed,
   output logic                res_nosnoop,
   output logic                res_idbased,
   output logic                res_digest,
   output logic [LEN_BITS:0]   res_length
);
   // the counter must hold the largest legal packet plus one excess word
   generate
      if ((2 ** CNT_W) < (2 ** LEN_BITS) + 6) begin : g_bad_cnt
         $error("CNT_W too small for the maximum packet");
      end
   endgenerate

   hdr_t             dec_hdr, cur_hdr;
   logic [CNT_W-1:0] cur_idx;
   logic             hi_zero, take;
   reason_t          reason;

   phc_hdr_decode u_dec (.dw0(in_data), .hdr(dec_hdr));

   phc_tracker #(.CNT_W(CNT_W)) u_trk (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop),
      .in_eop(in_eop), .in_data(in_data), .dec_hdr(dec_hdr),
      .cur_hdr(cur_hdr), .cur_idx(cur_idx), .hi_zero(hi_zero), .take(take)
   );

   phc_verdict #(.CNT_W(CNT_W), .ADDR_RULE_EN(ADDR_RULE_EN)) u_ver (
      .hdr(cur_hdr), .cur_idx(cur_idx), .hi_zero(hi_zero), .reason(reason)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         res_valid     <= 1'b0;
         res_malformed <= 1'b0;
         res_reason    <= RSN_OK;
         res_fmt       <= '0;
         res_kind      <= '0;
         res_tc        <= '0;
         res_relaxed   <= 1'b0;
         res_nosnoop   <= 1'b0;
         res_idbased   <= 1'b0;
         res_digest    <= 1'b0;
         res_length    <= '0;
      end else begin
         res_valid <= take && in_eop;
         if (take && in_eop) begin
            res_malformed <= (reason != RSN_OK);
            res_reason    <= reason;
            res_fmt       <= cur_hdr.fmt;
            res_kind      <= cur_hdr.kind;
            res_tc        <= cur_hdr.tc;
            res_relaxed   <= cur_hdr.relaxed;
            res_nosnoop   <= cur_hdr.nosnoop;
            res_idbased   <= cur_hdr.idbased;
            res_digest    <= cur_hdr.digest;
            res_length    <= len_words(cur_hdr.len_raw);
         end
      end
   end
endmodule

// File: rtl/phc_checker.sv
module phc_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       in_valid,
   input logic       in_eop,
   input logic       res_valid,
   input logic       res_malformed,
   input logic [2:0] res_reason,
   input logic [2:0] res_fmt,
   input logic [4:0] res_kind,
   input logic       res_digest
);
   // R9, R10: a strobe only follows an accepted end word
   a_r9_after_eop: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> $past(in_valid && in_eop));

   // R4: unsupported format always reports reason 1
   a_r4_bad_fmt: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_fmt[2]) |-> (res_malformed && res_reason == 3'd1));

   // R5: address reason limited to memory types with a 4-word header
   a_r5_addr_scope: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_reason == 3'd3) |-> (res_fmt[0] && !res_fmt[2] && res_kind[4:1] == 4'd0));

   // R7: missing-digest reason needs the digest bit
   a_r7_digest_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_reason == 3'd5) |-> res_digest);

   // R3, R12: short header only reported for supported formats
   a_r3_short_fmt: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_reason == 3'd2) |-> !res_fmt[2]);
endmodule

bind pkt_hdr_checker phc_checker u_phc_chk (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_eop(in_eop),
   .res_valid(res_valid), .res_malformed(res_malformed), .res_reason(res_reason),
   .res_fmt(res_fmt), .res_kind(res_kind), .res_digest(res_digest)
);

// File: tb/sim_pkt_hdr_checker.sv
`timescale 1ns/1ps
module sim_pkt_hdr_checker;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [31:0] in_data = '0;
   logic        res_valid, res_malformed, res_relaxed, res_nosnoop, res_idbased, res_digest;
   logic [2:0]  res_reason, res_fmt, res_tc;
   logic [4:0]  res_kind;
   logic [10:0] res_length;

   always #4 clk = ~clk; // 125 MHz

   pkt_hdr_checker u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sop(in_sop), .in_eop(in_eop),
      .in_data(in_data), .res_valid(res_valid), .res_malformed(res_malformed),
      .res_reason(res_reason), .res_fmt(res_fmt), .res_kind(res_kind), .res_tc(res_tc),
      .res_relaxed(res_relaxed), .res_nosnoop(res_nosnoop), .res_idbased(res_idbased),
      .res_digest(res_digest), .res_length(res_length)
   );

   typedef struct packed {
      logic [2:0]  reason;
      logic [2:0]  fmt;
      logic [4:0]  kind;
      logic [2:0]  tc;
      logic        ro, ns, ido, td;
      logic [10:0] len;
   } exp_t;

   exp_t exp_q[$];
   string tag_q[$];
   int checks = 0, errors = 0;
   bit done = 1'b0;

   function automatic logic [2:0] model_reason(logic [2:0] fmt, logic [4:0] kind, logic td,
                                               logic [9:0] len_raw, logic [31:0] hi, int total);
      int hs, body, lw;
      hs = fmt[0] ? 4 : 3;
      body = total - hs;
      lw = (len_raw == 0) ? 1024 : int'(len_raw);
      if (fmt[2]) return 3'd1;
      if (total < hs) return 3'd2;
      if (fmt[0] && (kind == 5'd0 || kind == 5'd1) && hi == 0) return 3'd3;
      if (fmt[1]) begin
         if (body < lw) return 3'd4;
         if (td && body == lw) return 3'd5;
         if (body > lw + int'(td)) return 3'd6;
      end else begin
         if (td && body == 0) return 3'd5;
         if (body > int'(td)) return 3'd6;
      end
      return 3'd0;
   endfunction

   // hdr_n < 0 sends the full header
   task automatic send(string tag, logic [2:0] fmt, logic [4:0] kind, logic [2:0] tc,
                       logic ro, logic ns, logic ido, logic td, logic [9:0] len_raw,
                       logic [31:0] hi, int hdr_n, int body_n);
      int hs, total;
      exp_t e;
      logic [31:0] w;
      hs = fmt[0] ? 4 : 3;
      total = ((hdr_n < 0) ? hs : hdr_n) + body_n;
      e.reason = model_reason(fmt, kind, td, len_raw, hi, total);
      e.fmt = fmt; e.kind = kind; e.tc = tc; e.ro = ro; e.ns = ns; e.ido = ido; e.td = td;
      e.len = (len_raw == 0) ? 11'd1024 : {1'b0, len_raw};
      exp_q.push_back(e);
      tag_q.push_back(tag);
      for (int i = 0; i < total; i++) begin
         @(negedge clk);
         if (i == 0)      w = {fmt, kind, 1'b0, tc, 1'b0, ido, 2'b00, td, 1'b0, ro, ns, 2'b00, len_raw};
         else if (i == 2) w = hi;
         else             w = 32'hA500_0000 + i;
         in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == total - 1); in_data = w;
      end
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
   endtask

   task automatic raw_word(logic sop, logic [31:0] w);
      @(negedge clk);
      in_valid = 1'b1; in_sop = sop; in_eop = 1'b0; in_data = w;
   endtask

   // monitor / scoreboard
   always @(negedge clk) begin
      if (rst_n && res_valid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL R9/R10/R11 unexpected result: reason=%0d expected no result", res_reason);
         end else begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (res_reason !== e.reason || res_malformed !== (e.reason != 0) ||
                res_fmt !== e.fmt || res_kind !== e.kind || res_tc !== e.tc ||
                res_relaxed !== e.ro || res_nosnoop !== e.ns || res_idbased !== e.ido ||
                res_digest !== e.td || res_length !== e.len) begin
               errors++;
               $display("FAIL %s: got reason=%0d mal=%0b fmt=%0d kind=%0d tc=%0d ro/ns/ido/td=%b%b%b%b len=%0d expected reason=%0d fmt=%0d kind=%0d tc=%0d ro/ns/ido/td=%b%b%b%b len=%0d",
                        t, res_reason, res_malformed, res_fmt, res_kind, res_tc, res_relaxed,
                        res_nosnoop, res_idbased, res_digest, res_length, e.reason, e.fmt,
                        e.kind, e.tc, e.ro, e.ns, e.ido, e.td, e.len);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: run hung, got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      checks++;
      if (res_valid !== 1'b0 || res_reason !== 3'd0) begin
         errors++;
         $display("FAIL R9 reset: got valid=%0b reason=%0d expected 0 0", res_valid, res_reason);
      end
      @(negedge clk); rst_n = 1'b1;

      send("R1 R9 3DW no payload ok",     3'b000, 5'd4, 3'd5, 1, 0, 1, 0, 10'd7, 32'h1, -1, 0);
      send("R1 R5 4DW mem hi nonzero ok",  3'b001, 5'd0, 3'd2, 0, 1, 0, 0, 10'd1, 32'h8, -1, 0);
      send("R5 4DW mem hi zero",           3'b001, 5'd0, 3'd0, 0, 0, 0, 0, 10'd1, 32'h0, -1, 0);
      send("R5 locked read hi zero",       3'b001, 5'd1, 3'd0, 0, 0, 0, 0, 10'd1, 32'h0, -1, 0);
      send("R5 non-memory type exempt",    3'b001, 5'd4, 3'd0, 0, 0, 0, 0, 10'd1, 32'h0, -1, 0);
      send("R6 payload exact",             3'b010, 5'd0, 3'd7, 1, 1, 1, 0, 10'd5, 32'h0, -1, 5);
      send("R6 payload short",             3'b010, 5'd0, 3'd1, 0, 0, 0, 0, 10'd5, 32'h0, -1, 4);
      send("R8 payload long",              3'b010, 5'd0, 3'd1, 0, 0, 0, 0, 10'd5, 32'h0, -1, 6);
      send("R7 digest present ok",         3'b011, 5'd0, 3'd3, 0, 0, 0, 1, 10'd3, 32'h9, -1, 4);
      send("R7 digest missing",            3'b011, 5'd0, 3'd3, 0, 0, 0, 1, 10'd3, 32'h9, -1, 3);
      send("R7 no-payload digest missing", 3'b000, 5'd4, 3'd0, 0, 0, 0, 1, 10'd0, 32'h0, -1, 0);
      send("R7 no-payload digest ok",      3'b000, 5'd4, 3'd0, 0, 0, 0, 1, 10'd0, 32'h0, -1, 1);
      send("R8 no-payload excess len ignored", 3'b000, 5'd4, 3'd0, 0, 0, 0, 0, 10'd2, 32'h0, -1, 2);
      send("R2 zero length 1024 ok",       3'b010, 5'd0, 3'd0, 0, 0, 0, 0, 10'd0, 32'h0, -1, 1024);
      send("R2 zero length one word",      3'b010, 5'd0, 3'd0, 0, 0, 0, 0, 10'd0, 32'h0, -1, 1);
      send("R4 unsupported format",        3'b100, 5'd0, 3'd0, 0, 0, 0, 0, 10'd1, 32'h0, -1, 1);
      send("R3 4DW header short",          3'b011, 5'd0, 3'd0, 0, 0, 0, 0, 10'd1, 32'h0, 3, 0);
      send("R3 R12 single word",           3'b000, 5'd4, 3'd0, 0, 0, 0, 0, 10'd0, 32'h0, 1, 0);
      send("R12 bad fmt beats short hdr",  3'b101, 5'd0, 3'd0, 0, 0, 0, 0, 10'd1, 32'h0, 1, 0);
      send("R12 addr beats short payload", 3'b011, 5'd0, 3'd0, 0, 0, 0, 1, 10'd4, 32'h0, -1, 1);

      // R10: stray words outside a packet
      raw_word(1'b0, 32'h4000_0001);
      raw_word(1'b0, 32'h0);
      @(negedge clk); in_valid = 1'b0;
      send("R10 packet after stray words", 3'b010, 5'd0, 3'd0, 0, 0, 0, 0, 10'd2, 32'h0, -1, 2);

      // R11: abandoned packet, then a new start
      raw_word(1'b1, 32'h4000_0009);
      raw_word(1'b0, 32'h1);
      send("R11 restart mid-packet",       3'b000, 5'd4, 3'd6, 1, 0, 0, 0, 10'd3, 32'h0, -1, 0);

      repeat (5) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R9 missing results: got %0d pending expected 0", exp_q.size());
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule